// File: doc/BRIEF.md
# Dual-Source Priority SPI Serializer

This block is an SPI master that shares one 16-bit shift register between two producers of frames. The first producer is a queue of command frames. Each command frame arrives over a valid/ready handshake with its own timing-profile select. The second producer is a bank of 16 parallel input pins. The block registers these pins on every system clock. When automatic mode is enabled and the registered pin word differs from the last word sent from the pins, the block serializes that word by itself.

At each frame boundary the block arbitrates between the two producers. A waiting command frame always wins, but a frame that is already in progress runs to completion. Each source has its own active-low chip select. Each source also has its own timing profile, which sets the SCK half period, the CS-to-SCK lead, the lag after the last SCK, and the idle gap between frames. The word received during a command frame is pushed toward a receive queue. If that queue is full, the word is discarded and a sticky flag is set. The word received during a pin frame goes to a parallel output register. A copy of each pin frame that is sent is kept in a comparison register, and this copy is what the change detection compares against.

Top module: `dual_src_spi_master`

## Requirements
- R1: `par_in` is registered on every rising `clk` edge. With `auto_en` high, no command waiting and the block idle, a registered word that differs from `cmp_out` starts a pin frame that sends that word. At that start `cmp_out` takes the same word.
- R2: While idle, `cmd_valid` high starts a command frame ahead of any pin frame, and `cmd_ready` is high only while idle. A command that arrives during a pin frame waits until that frame, including its gap, has ended.
- R3: `cs_cmd_n` goes low for command frames only and `cs_auto_n` goes low for pin frames only. They are never low together, and both return high after the lag that follows the last SCK.
- R4: At the end of a command frame with `rx_ready` high, `rx_valid` pulses for one cycle with the received word on `rx_data`. At the end of a pin frame, `par_out` takes the received word, and `rx_valid` stays low.
- R5: If `rx_ready` is low when a command frame ends, the received word is dropped (no `rx_valid` pulse) and `rx_ovf` goes high. It stays high until reset.
- R6: A command frame uses the profile indexed by the `cmd_prof` presented with it. A pin frame uses the profile indexed by `auto_prof`. Profile i occupies bits [i*CW +: CW] of `prof_div`, `prof_lead`, `prof_lag` and `prof_gap`.
- R7: SCK high and low phases each last `prof_div` clocks, with a value of 0 acting as 1. The first SCK rise comes `prof_lead`+1 clocks after the chip select falls.
- R8: Mode 0, MSB first: SCK idles low, `sout` presents bit 15 from chip-select fall and changes only on SCK falls, and `sin` is sampled on each of the 16 SCK rises, first bit into the MSB.
- R9: With `auto_en` low, or with the registered word equal to `cmp_out`, no pin frame starts and `cmp_out` holds.
- R10: After reset both chip selects are high, `sck` is 0, `busy`, `rx_valid` and `rx_ovf` are 0, `par_out` and `cmp_out` are 0, and `cmd_ready` is 1. `busy` is high from chip-select fall until the gap ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command frame waiting |
| cmd_data | input | FW | Command frame word |
| cmd_prof | input | PSW | Profile index for the command frame |
| cmd_ready | output | 1 | Command accepted on this edge if valid |
| rx_valid | output | 1 | Received command-frame word is valid |
| rx_data | output | FW | Received command-frame word |
| rx_ready | input | 1 | Receive queue has space |
| rx_ovf | output | 1 | Sticky: received word dropped |
| par_in | input | FW | Parallel input pins |
| par_out | output | FW | Word received in the last pin frame |
| cmp_out | output | FW | Copy of the last pin word sent |
| auto_en | input | 1 | Enable automatic pin frames |
| auto_prof | input | PSW | Profile index for pin frames |
| prof_div | input | NPROF*CW | Per-profile SCK half period |
| prof_lead | input | NPROF*CW | Per-profile CS-to-SCK lead |
| prof_lag | input | NPROF*CW | Per-profile SCK-to-CS-release lag |
| prof_gap | input | NPROF*CW | Per-profile idle gap after a frame |
| sck | output | 1 | Serial clock |
| sout | output | 1 | Serial data out |
| sin | input | 1 | Serial data in |
| cs_cmd_n | output | 1 | Chip select for command frames |
| cs_auto_n | output | 1 | Chip select for pin frames |
| busy | output | 1 | Frame in progress |

## Verification
A corrupted arbitration state shows up within one frame boundary: the wrong chip select falls, or a pin frame starts while a command is waiting. A stale comparison register shows up in a few clocks as an extra frame, or a missing one, once the pins change. An error in the bit counter or the profile counters changes the SCK phase widths, the lead time or the bits captured on `sout`. That is visible before chip select rises, and the misrouted or shifted received word is then visible at `rx_data` or `par_out` on the release edge.

// File: rtl/dss_pkg.sv
`timescale 1ns/1ps
package dss_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_HI, ST_LO, ST_LAG, ST_GAP
  } dss_state_e;

  typedef enum logic {
    SRC_CMD  = 1'b0,
    SRC_AUTO = 1'b1
  } dss_src_e;
endpackage

// File: rtl/dss_sampler.sv
`timescale 1ns/1ps
// Registers the pin word each clock and keeps the copy of the last pin frame sent.
module dss_sampler #(
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] pins,
  input  logic          take,
  output logic [FW-1:0] snap,
  output logic [FW-1:0] last_sent,
  output logic          differs
);
  always_ff @(posedge clk) begin
    if (rst) begin
      snap      <= '0;
      last_sent <= '0;
    end else begin
      snap <= pins;
      if (take) last_sent <= snap;
    end
  end

  assign differs = (snap != last_sent);
endmodule

// File: rtl/dss_profile_mux.sv
`timescale 1ns/1ps
// Picks one timing profile out of the flattened profile vectors.
module dss_profile_mux #(
  parameter int NPROF = 2,
  parameter int CW    = 8,
  parameter int PSW   = 1
) (
  input  logic [PSW-1:0]      sel,
  input  logic [NPROF*CW-1:0] all_div,
  input  logic [NPROF*CW-1:0] all_lead,
  input  logic [NPROF*CW-1:0] all_lag,
  input  logic [NPROF*CW-1:0] all_gap,
  output logic [CW-1:0]       div_eff,
  output logic [CW-1:0]       lead,
  output logic [CW-1:0]       lag,
  output logic [CW-1:0]       gap
);
  logic [CW-1:0] div_raw;

  always_comb begin
    div_raw = all_div[CW-1:0];
    lead    = all_lead[CW-1:0];
    lag     = all_lag[CW-1:0];
    gap     = all_gap[CW-1:0];
    for (int i = 1; i < NPROF; i++) begin
      if (PSW'(i) == sel) begin
        div_raw = all_div[i*CW +: CW];
        lead    = all_lead[i*CW +: CW];
        lag     = all_lag[i*CW +: CW];
        gap     = all_gap[i*CW +: CW];
      end
    end
  end

  assign div_eff = (div_raw == '0) ? CW'(1) : div_raw;
endmodule

// File: rtl/dss_shifter.sv
`timescale 1ns/1ps
// Frame sequencer: lead, 16 mode-0 SCK periods, lag, gap.
module dss_shifter
  import dss_pkg::*;
#(
  parameter int FW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  dss_src_e      start_src,
  input  logic [FW-1:0] start_word,
  input  logic [CW-1:0] div_eff,
  input  logic [CW-1:0] lead,
  input  logic [CW-1:0] lag,
  input  logic [CW-1:0] gap,
  input  logic          sin,
  output logic          idle,
  output logic          done,
  output dss_src_e      done_src,
  output logic [FW-1:0] rx_word,
  output logic          sck,
  output logic          sout,
  output logic          cs_cmd_n,
  output logic          cs_auto_n
);
  localparam int BW = (FW > 1) ? $clog2(FW) : 1;
  localparam logic [BW-1:0] LAST = BW'(FW - 1);

  dss_state_e    st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitc;
  logic [FW-1:0] tx_sh;
  logic [FW-1:0] rx_sh;
  dss_src_e      src_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      bitc      <= '0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      src_q     <= SRC_CMD;
      sck       <= 1'b0;
      cs_cmd_n  <= 1'b1;
      cs_auto_n <= 1'b1;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          src_q <= start_src;
          tx_sh <= start_word;
          bitc  <= '0;
          cnt   <= lead;
          st    <= ST_LEAD;
          if (start_src == SRC_CMD) cs_cmd_n  <= 1'b0;
          else                      cs_auto_n <= 1'b0;
        end
        ST_LEAD: if (cnt == '0) begin
          sck   <= 1'b1;
          rx_sh <= {rx_sh[FW-2:0], sin};
          cnt   <= div_eff - CW'(1);
          st    <= ST_HI;
        end else cnt <= cnt - CW'(1);
        ST_HI: if (cnt == '0) begin
          sck   <= 1'b0;
          tx_sh <= {tx_sh[FW-2:0], 1'b0};
          if (bitc == LAST) begin
            cnt <= lag;
            st  <= ST_LAG;
          end else begin
            bitc <= bitc + BW'(1);
            cnt  <= div_eff - CW'(1);
            st   <= ST_LO;
          end
        end else cnt <= cnt - CW'(1);
        ST_LO: if (cnt == '0) begin
          sck   <= 1'b1;
          rx_sh <= {rx_sh[FW-2:0], sin};
          cnt   <= div_eff - CW'(1);
          st    <= ST_HI;
        end else cnt <= cnt - CW'(1);
        ST_LAG: if (cnt == '0) begin
          cs_cmd_n  <= 1'b1;
          cs_auto_n <= 1'b1;
          cnt       <= gap;
          st        <= ST_GAP;
        end else cnt <= cnt - CW'(1);
        ST_GAP: if (cnt == '0) st <= ST_IDLE;
                else cnt <= cnt - CW'(1);
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign idle     = (st == ST_IDLE);
  assign done     = (st == ST_LAG) && (cnt == '0);
  assign done_src = src_q;
  assign rx_word  = rx_sh;
  assign sout     = tx_sh[FW-1];
endmodule

// File: rtl/dual_src_spi_master.sv
`timescale 1ns/1ps
module dual_src_spi_master
  import dss_pkg::*;
#(
  parameter int FW    = 16,
  parameter int NPROF = 2,
  parameter int CW    = 8,
  parameter int PSW   = (NPROF > 1) ? $clog2(NPROF) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  input  logic [FW-1:0]       cmd_data,
  input  logic [PSW-1:0]      cmd_prof,
  output logic                cmd_ready,
  output logic                rx_valid,
  output logic [FW-1:0]       rx_data,
  input  logic                rx_ready,
  output logic                rx_ovf,
  input  logic [FW-1:0]       par_in,
  output logic [FW-1:0]       par_out,
  output logic [FW-1:0]       cmp_out,
  input  logic                auto_en,
  input  logic [PSW-1:0]      auto_prof,
  input  logic [NPROF*CW-1:0] prof_div,
  input  logic [NPROF*CW-1:0] prof_lead,
  input  logic [NPROF*CW-1:0] prof_lag,
  input  logic [NPROF*CW-1:0] prof_gap,
  output logic                sck,
  output logic                sout,
  input  logic                sin,
  output logic                cs_cmd_n,
  output logic                cs_auto_n,
  output logic                busy
);
  logic          idle, done, differs;
  logic          start_cmd, start_auto, start;
  dss_src_e      start_src, done_src;
  logic [FW-1:0] snap, rx_word;
  logic [PSW-1:0] cur_prof, pick_prof;
  logic [CW-1:0] div_eff, lead, lag, gap;

  // Frame-boundary arbitration: a waiting command always wins.
  assign start_cmd  = idle && cmd_valid;
  assign start_auto = idle && !cmd_valid && auto_en && differs;
  assign start      = start_cmd || start_auto;
  assign start_src  = start_cmd ? SRC_CMD : SRC_AUTO;
  assign pick_prof  = idle ? (cmd_valid ? cmd_prof : auto_prof) : cur_prof;

  always_ff @(posedge clk) begin
    if (rst) cur_prof <= '0;
    else if (start) cur_prof <= pick_prof;
  end

  dss_sampler #(.FW(FW)) u_samp (
    .clk(clk), .rst(rst), .pins(par_in), .take(start_auto),
    .snap(snap), .last_sent(cmp_out), .differs(differs)
  );

  dss_profile_mux #(.NPROF(NPROF), .CW(CW), .PSW(PSW)) u_prof (
    .sel(pick_prof), .all_div(prof_div), .all_lead(prof_lead),
    .all_lag(prof_lag), .all_gap(prof_gap),
    .div_eff(div_eff), .lead(lead), .lag(lag), .gap(gap)
  );

  dss_shifter #(.FW(FW), .CW(CW)) u_shift (
    .clk(clk), .rst(rst), .start(start), .start_src(start_src),
    .start_word(start_cmd ? cmd_data : snap),
    .div_eff(div_eff), .lead(lead), .lag(lag), .gap(gap), .sin(sin),
    .idle(idle), .done(done), .done_src(done_src), .rx_word(rx_word),
    .sck(sck), .sout(sout), .cs_cmd_n(cs_cmd_n), .cs_auto_n(cs_auto_n)
  );

  // Return-data routing, registered on the chip-select release edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_ovf   <= 1'b0;
      par_out  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (done) begin
        if (done_src == SRC_AUTO) par_out <= rx_word;
        else if (rx_ready) begin
          rx_valid <= 1'b1;
          rx_data  <= rx_word;
        end else rx_ovf <= 1'b1;
      end
    end
  end

  assign cmd_ready = idle;
  assign busy      = !idle;
endmodule

// File: rtl/dss_checker.sv
`timescale 1ns/1ps
module dss_checker #(
  parameter int FW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic          rx_ovf,
  input logic [FW-1:0] par_out,
  input logic [FW-1:0] cmp_out,
  input logic          sck,
  input logic          cs_cmd_n,
  input logic          cs_auto_n,
  input logic          busy
);
  p_cs_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
    !(!cs_cmd_n && !cs_auto_n));

  p_sck_in_frame_r8: assert property (@(posedge clk) disable iff (rst)
    sck |-> (!cs_cmd_n || !cs_auto_n));

  p_cmd_cs_needs_valid_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_cmd_n) |-> ($past(cmd_valid) && $past(cmd_ready)));

  p_auto_yields_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_auto_n) |-> !$past(cmd_valid));

  p_cmp_on_auto_start_r1: assert property (@(posedge clk) disable iff (rst)
    !$stable(cmp_out) |-> $fell(cs_auto_n));

  p_par_out_on_auto_end_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(par_out) |-> $rose(cs_auto_n));

  p_no_push_when_full_r5: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> ($past(rx_ready) && $rose(cs_cmd_n)));

  p_no_overflow_clear_r5: assert property (@(posedge clk) disable iff (rst)
    rx_ovf |=> rx_ovf);

  p_busy_covers_cs_r10: assert property (@(posedge clk) disable iff (rst)
    (!cs_cmd_n || !cs_auto_n) |-> busy);
endmodule

bind dual_src_spi_master dss_checker #(.FW(FW)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_ovf(rx_ovf),
  .par_out(par_out), .cmp_out(cmp_out), .sck(sck),
  .cs_cmd_n(cs_cmd_n), .cs_auto_n(cs_auto_n), .busy(busy)
);

// File: tb/dual_src_spi_master_test.sv
`timescale 1ns/1ps
module dual_src_spi_master_test;
  localparam int FW = 16, NPROF = 2, CW = 8, PSW = 1;
  localparam int NV = 6;
  // {is_auto, profile, tx word, slave return word}
  localparam logic [33:0] VEC [NV] = '{
    {1'b0, 1'b0, 16'hA5C3, 16'h3C5A},
    {1'b1, 1'b1, 16'h8001, 16'h7FFE},
    {1'b0, 1'b1, 16'hFFFF, 16'h0000},
    {1'b1, 1'b0, 16'h1234, 16'hFEDC},
    {1'b0, 1'b0, 16'h0001, 16'h8000},
    {1'b1, 1'b1, 16'h0000, 16'hAAAA}
  };
  // profile 0: div 0 (acts as 1), lead 0; profile 1: div 3, lead 2
  localparam int EXP_HI [2]   = '{1, 3};
  localparam int EXP_LEAD [2] = '{1, 3};

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [FW-1:0] cmd_data = '0;
  logic [PSW-1:0] cmd_prof = '0, auto_prof = '0;
  logic cmd_ready, rx_valid, rx_ovf, sck, sout, cs_cmd_n, cs_auto_n, busy;
  logic [FW-1:0] rx_data, par_out, cmp_out;
  logic rx_ready = 1'b1, auto_en = 1'b0, sin;
  logic [FW-1:0] par_in = '0;
  logic [NPROF*CW-1:0] prof_div  = {8'd3, 8'd0};
  logic [NPROF*CW-1:0] prof_lead = {8'd2, 8'd0};
  logic [NPROF*CW-1:0] prof_lag  = {8'd1, 8'd0};
  logic [NPROF*CW-1:0] prof_gap  = {8'd2, 8'd0};

  always #4 clk = ~clk;

  dual_src_spi_master #(.FW(FW), .NPROF(NPROF), .CW(CW)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .cmd_prof(cmd_prof), .cmd_ready(cmd_ready), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ready(rx_ready), .rx_ovf(rx_ovf),
    .par_in(par_in), .par_out(par_out), .cmp_out(cmp_out),
    .auto_en(auto_en), .auto_prof(auto_prof), .prof_div(prof_div),
    .prof_lead(prof_lead), .prof_lag(prof_lag), .prof_gap(prof_gap),
    .sck(sck), .sout(sout), .sin(sin), .cs_cmd_n(cs_cmd_n),
    .cs_auto_n(cs_auto_n), .busy(busy)
  );

  int nchk = 0, nfail = 0;
  // Frame monitor and slave model, all at the falling clock edge.
  int nfr = 0, nrx = 0;
  int f_auto [32];
  int f_hi [32];
  int f_lead [32];
  logic [FW-1:0] f_mosi [32];
  logic [FW-1:0] rx_log [32];
  logic [FW-1:0] slave_ret = '0, slv = '0, mosi = '0;
  bit in_fr = 0, seen_hi = 0, prev_sck = 0;
  int lead_c = 0, hi_run = 0, hi_w = 0, kind = 0;

  assign sin = slv[FW-1];

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin rx_log[nrx % 32] = rx_data; nrx++; end
      if ((!cs_cmd_n || !cs_auto_n) && !in_fr) begin
        in_fr = 1; kind = !cs_auto_n ? 1 : 0;
        lead_c = 0; seen_hi = 0; hi_run = 0; hi_w = 0;
        slv = slave_ret; mosi = '0;
      end
      if (in_fr) begin
        if (!cs_cmd_n || !cs_auto_n) begin
          if (sck && !prev_sck) mosi = {mosi[FW-2:0], sout};
          if (!sck && prev_sck) slv = {slv[FW-2:0], 1'b0};
          if (!sck && !seen_hi) lead_c++;
          if (sck) begin seen_hi = 1; hi_run++; end
          else if (hi_run > 0 && hi_w == 0) hi_w = hi_run;
        end else begin
          f_auto[nfr % 32] = kind; f_mosi[nfr % 32] = mosi;
          f_hi[nfr % 32] = hi_w; f_lead[nfr % 32] = lead_c;
          nfr++; in_fr = 0;
        end
      end
      prev_sck = sck;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_cmd(logic [FW-1:0] w, logic [PSW-1:0] p);
    @(negedge clk);
    cmd_data = w; cmd_prof = p; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_frames(int n);
    while (nfr < n) @(negedge clk);
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int n0, r0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check("R10 reset cs", {cs_cmd_n, cs_auto_n, sck, busy}, 32'b1100);
    check("R10 reset flags", {rx_valid, rx_ovf, cmd_ready}, 32'b001);
    check("R10 reset words", {par_out, cmp_out}, 32'h0);
    auto_en = 1'b1;

    // Table walk: R1 R3 R4 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      logic [33:0] e;
      e = VEC[v];
      n0 = nfr; r0 = nrx;
      slave_ret = e[15:0];
      if (e[33]) begin
        @(negedge clk); auto_prof = e[32]; par_in = e[31:16];
      end else push_cmd(e[31:16], e[32]);
      wait_frames(n0 + 1);
      check("R3 chip select of source", f_auto[n0 % 32], {31'b0, e[33]});
      check("R8 mosi word", f_mosi[n0 % 32], e[31:16]);
      check("R7 R6 sck half period", f_hi[n0 % 32], EXP_HI[e[32]]);
      check("R7 R6 lead time", f_lead[n0 % 32], EXP_LEAD[e[32]]);
      if (e[33]) begin
        check("R4 par_out", par_out, e[15:0]);
        check("R1 cmp_out copy", cmp_out, e[31:16]);
        check("R4 no rx push", nrx, r0);
      end else begin
        check("R4 rx push count", nrx, r0 + 1);
        check("R4 R8 rx word", rx_log[r0 % 32], e[15:0]);
      end
    end

    // R2: command arriving mid pin frame waits, then beats the next pin frame
    n0 = nfr; slave_ret = 16'h5A5A;
    @(negedge clk); auto_prof = 1'b1; par_in = 16'h0F0F;
    while (!busy) @(negedge clk);
    par_in = 16'hB00B;
    push_cmd(16'hC001, 1'b0);
    wait_frames(n0 + 3);
    check("R2 first frame kept", {f_auto[n0 % 32][15:0], f_mosi[n0 % 32]}, {16'd1, 16'h0F0F});
    check("R2 command next", {f_auto[(n0+1) % 32][15:0], f_mosi[(n0+1) % 32]}, {16'd0, 16'hC001});
    check("R2 pin frame after", {f_auto[(n0+2) % 32][15:0], f_mosi[(n0+2) % 32]}, {16'd1, 16'hB00B});
    check("R1 cmp after priority", cmp_out, 16'hB00B);

    // R9: disabled automatic mode, then unchanged pins
    n0 = nfr;
    @(negedge clk); auto_en = 1'b0; par_in = 16'h5555;
    repeat (40) @(negedge clk);
    check("R9 no frame when disabled", nfr, n0);
    check("R9 cmp holds when disabled", cmp_out, 16'hB00B);
    auto_en = 1'b1;
    wait_frames(n0 + 1);
    check("R1 frame after enable", f_mosi[n0 % 32], 16'h5555);
    repeat (40) @(negedge clk);
    check("R9 no frame when equal", nfr, n0 + 1);

    // R5: overflow when receive queue is full
    r0 = nrx; n0 = nfr; rx_ready = 1'b0;
    push_cmd(16'h0BAD, 1'b0);
    wait_frames(n0 + 1);
    check("R5 word dropped", nrx, r0);
    check("R5 overflow set", rx_ovf, 1'b1);
    rx_ready = 1'b1; slave_ret = 16'h1357;
    push_cmd(16'h2468, 1'b1);
    wait_frames(n0 + 2);
    check("R5 overflow sticky", rx_ovf, 1'b1);
    check("R5 push resumes", {nrx[15:0], rx_log[r0 % 32]}, {r0[15:0] + 16'd1, 16'h1357});

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule